// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host writes into a holding register. When the shifter is free, the byte moves from the holding register into the shift stage, and the holding register can then accept the next byte while the current frame is still on the line. A frame is a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional extra slot, then one or two high stop bits. The extra slot carries either an even or odd parity bit or a multiprocessor marker bit. Between frames the line rests high.

Two status flags report progress. The empty flag reads 1 when the holding register has been handed to the shifter and can take another byte. The end flag reads 1 when the last frame has reached its stop bits and nothing is waiting to follow it. The holding register is checked at the moment the stop bits begin. If a byte is pending at that moment, it follows the stop bits with no idle time between frames. Each flag drives an interrupt request through its own enable. An external one-cycle strobe, `bit_tick`, paces the bit timing, and each bit lasts a fixed number of strobes.

Top module: `async_tx_buffered`

## Requirements
- R1: While reset is active and right after it, `txd` is 1, `flag_empty` is 1 and `flag_end` is 1.
- R2: A host write (`wr_en` high at a clock edge) clears both `flag_empty` and `flag_end`, and they read 0 after that edge.
- R3: When the line is idle and a byte is pending, the byte moves into the shifter on the next clock edge. At that edge `flag_empty` returns to 1 and `txd` drops to 0 for the start bit.
- R4: A frame has one 0 start bit, then the data bits least significant bit first. There are 8 data bits when `cfg_len7`=0 and 7 bits (bits 6..0) when `cfg_len7`=1.
- R5: `cfg_ext_mode` selects the slot after the data. 2'b01 sends a parity bit that makes the number of ones in data plus parity even, or odd when `cfg_par_odd`=1. 2'b10 sends the value of `cfg_mp_bit`. 2'b00 and 2'b11 send no extra slot.
- R6: A frame ends with one 1 stop bit, or two when `cfg_two_stop`=1.
- R7: Every bit of a frame, start and stop bits included, lasts exactly `TICKS_PER_BIT` cycles in which `bit_tick` is high. `txd` changes only on a cycle in which a strobe ends a bit, or on a load from idle.
- R8: Outside a frame `txd` stays 1.
- R9: If a byte is pending when the stop bits begin, that byte is taken at that moment (`flag_empty` goes to 1). Its start bit follows the last stop bit with no idle bit time between the frames.
- R10: If nothing is pending when the stop bits begin, `flag_end` becomes 1 at that moment. After the stop bits, the line returns to idle.
- R11: `irq_empty` equals `flag_empty` AND `irq_empty_en`, and `irq_end` equals `flag_end` AND `irq_end_en`.
- R12: The configuration inputs are captured only when a byte is loaded from idle. A frame chained behind it uses the same captured settings, and changing the inputs during a frame has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte written by the host |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_ext_mode | input | 2 | Extra slot: 01 parity, 10 multiprocessor bit, others none |
| cfg_par_odd | input | 1 | 1 selects odd parity |
| cfg_mp_bit | input | 1 | Value sent in the multiprocessor slot |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| irq_empty_en | input | 1 | Enable for the data-empty request |
| irq_end_en | input | 1 | Enable for the transmit-end request |
| txd | output | 1 | Serial line |
| flag_empty | output | 1 | Holding register free |
| flag_end | output | 1 | Transmission finished with nothing pending |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
On every cycle, the embedded properties check four things. A write clears both flags. An idle shifter with a pending byte empties the holding register one cycle later. The end flag rises only while the holding register is empty. The line and the captured configuration stay still between bit strobes and for the whole of a frame.

The frame contents, the parity and marker values, the stop-bit count, and the exact length of each bit in strobes can only be shown by the bench. It decodes the line into bits and compares them with frames it builds itself from the written byte and the settings. The bench's scenarios also cover the following:
- back-to-back chaining with zero idle time
- the end flag's value at the first stop bit
- configuration changes made in the middle of a frame

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_EXT,
      ST_STOP
   } tx_state_e;

   localparam logic [1:0] EXT_NONE   = 2'b00;
   localparam logic [1:0] EXT_PARITY = 2'b01;
   localparam logic [1:0] EXT_MARKER = 2'b10;

   typedef struct packed {
      logic       len7;
      logic [1:0] ext_mode;
      logic       par_odd;
      logic       mp_bit;
      logic       two_stop;
   } tx_cfg_t;

   function automatic logic ext_slot_used(tx_cfg_t c);
      return (c.ext_mode == EXT_PARITY) || (c.ext_mode == EXT_MARKER);
   endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
   parameter int TICKS_PER_BIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic bit_tick,
   output logic bit_end
);

   if (TICKS_PER_BIT < 1) begin : g_bad_tpb
      $error("TICKS_PER_BIT must be at least 1");
   end

   if (TICKS_PER_BIT == 1) begin : g_single
      assign bit_end = run & bit_tick & ~clear;
   end else begin : g_count
      localparam int CW = $clog2(TICKS_PER_BIT);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clear) begin
            cnt_q <= '0;
         end else if (run && bit_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign bit_end = run & bit_tick & ~clear & (cnt_q == LAST);
   end

endmodule

// File: rtl/tx_hold_buffer.sv
module tx_hold_buffer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              set_end,
   input  logic              idle_i,
   output logic [DATA_W-1:0] hold_data,
   output logic              flag_empty,
   output logic              flag_end
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data  <= '0;
         flag_empty <= 1'b1;
         flag_end   <= 1'b1;
      end else if (wr_en) begin
         hold_data  <= wr_data;
         flag_empty <= 1'b0;
         flag_end   <= 1'b0;
      end else begin
         if (take)    flag_empty <= 1'b1;
         if (set_end) flag_end   <= 1'b1;
      end
   end

   a_r2_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !flag_empty);

   a_r2_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !flag_end);

   a_r3_idle_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && !flag_empty && !wr_en) |=> flag_empty);

   a_r10_end_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_end) |-> flag_empty);

endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
   import async_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              bit_end,
   input  tx_cfg_t           cfg_in,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   output logic              take,
   output logic              set_end,
   output logic              idle,
   output logic              txd
);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);
   localparam logic [DATA_W-1:0] MASK_FULL  = '1;
   localparam logic [DATA_W-1:0] MASK_SHORT = {1'b0, {(DATA_W-1){1'b1}}};

   tx_state_e         state_q;
   logic [DATA_W-1:0] shreg_q;
   logic              ext_q;
   tx_cfg_t           cfg_q;
   logic              chain_q;
   logic              stop2_q;
   logic [IDX_W-1:0]  bit_idx_q;

   function automatic logic ext_value(logic [DATA_W-1:0] d, tx_cfg_t c);
      logic p;
      p = ^(d & (c.len7 ? MASK_SHORT : MASK_FULL));
      if (c.ext_mode == EXT_PARITY) return p ^ c.par_odd;
      if (c.ext_mode == EXT_MARKER) return c.mp_bit;
      return 1'b1;
   endfunction

   tx_cfg_t          ld_cfg;
   logic             ld_ext;
   logic [IDX_W-1:0] last_idx;
   logic             data_last;
   logic             stop_entry;

   always_comb begin
      ld_cfg     = (state_q == ST_IDLE) ? cfg_in : cfg_q;
      ld_ext     = ext_value(hold_data, ld_cfg);
      last_idx   = cfg_q.len7 ? IDX_SHORT : IDX_FULL;
      idle       = (state_q == ST_IDLE);
      data_last  = (state_q == ST_DATA) && bit_end && (bit_idx_q == last_idx);
      stop_entry = (data_last && !ext_slot_used(cfg_q)) ||
                   ((state_q == ST_EXT) && bit_end);
      take       = hold_full && (idle || stop_entry);
      set_end    = stop_entry && !hold_full;
      case (state_q)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = shreg_q[0];
         ST_EXT:   txd = ext_q;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         shreg_q   <= '0;
         ext_q     <= 1'b1;
         cfg_q     <= '0;
         chain_q   <= 1'b0;
         stop2_q   <= 1'b0;
         bit_idx_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (hold_full) begin
                  shreg_q <= hold_data;
                  ext_q   <= ld_ext;
                  cfg_q   <= cfg_in;
                  state_q <= ST_START;
               end
            end
            ST_START: begin
               if (bit_end) begin
                  state_q   <= ST_DATA;
                  bit_idx_q <= '0;
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  shreg_q   <= shreg_q >> 1;
                  bit_idx_q <= bit_idx_q + 1'b1;
                  if (bit_idx_q == last_idx) begin
                     state_q <= ext_slot_used(cfg_q) ? ST_EXT : ST_STOP;
                  end
               end
            end
            ST_EXT: begin
               if (bit_end) state_q <= ST_STOP;
            end
            ST_STOP: begin
               if (bit_end) begin
                  if (cfg_q.two_stop && !stop2_q) begin
                     stop2_q <= 1'b1;
                  end else begin
                     state_q <= chain_q ? ST_START : ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (stop_entry) begin
            stop2_q <= 1'b0;
            chain_q <= hold_full;
            if (hold_full) begin
               shreg_q <= hold_data;
               ext_q   <= ld_ext;
            end
         end
      end
   end

   a_r7_line_still_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !idle) |=> $stable(txd));

   a_r12_cfg_frozen_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(cfg_q));

endmodule

// File: rtl/async_tx_buffered.sv
module async_tx_buffered
   import async_tx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cfg_len7,
   input  logic [1:0]        cfg_ext_mode,
   input  logic              cfg_par_odd,
   input  logic              cfg_mp_bit,
   input  logic              cfg_two_stop,
   input  logic              irq_empty_en,
   input  logic              irq_end_en,
   output logic              txd,
   output logic              flag_empty,
   output logic              flag_end,
   output logic              irq_empty,
   output logic              irq_end
);

   tx_cfg_t           cfg_in;
   logic [DATA_W-1:0] hold_data;
   logic              take;
   logic              set_end;
   logic              idle;
   logic              bit_end;

   assign cfg_in = '{len7: cfg_len7, ext_mode: cfg_ext_mode, par_odd: cfg_par_odd,
                     mp_bit: cfg_mp_bit, two_stop: cfg_two_stop};

   tx_hold_buffer #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .take      (take),
      .set_end   (set_end),
      .idle_i    (idle),
      .hold_data (hold_data),
      .flag_empty(flag_empty),
      .flag_end  (flag_end)
   );

   tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (idle),
      .run     (!idle),
      .bit_tick(bit_tick),
      .bit_end (bit_end)
   );

   tx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .bit_end  (bit_end),
      .cfg_in   (cfg_in),
      .hold_full(!flag_empty),
      .hold_data(hold_data),
      .take     (take),
      .set_end  (set_end),
      .idle     (idle),
      .txd      (txd)
   );

   assign irq_empty = flag_empty & irq_empty_en;
   assign irq_end   = flag_end & irq_end_en;

endmodule

// File: tb/test_async_tx_buffered.sv
module test_async_tx_buffered;

   localparam int CLK_PERIOD = 10;
   localparam int TPB        = 4;

   logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cfg_len7 = 1'b0, cfg_par_odd = 1'b0, cfg_mp_bit = 1'b0, cfg_two_stop = 1'b0;
   logic [1:0] cfg_ext_mode = 2'b00;
   logic       irq_empty_en = 1'b0, irq_end_en = 1'b0;
   logic       txd, flag_empty, flag_end, irq_empty, irq_end;

   async_tx_buffered #(.DATA_W(8), .TICKS_PER_BIT(TPB)) i_async_tx_buffered (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
      .cfg_len7(cfg_len7), .cfg_ext_mode(cfg_ext_mode), .cfg_par_odd(cfg_par_odd),
      .cfg_mp_bit(cfg_mp_bit), .cfg_two_stop(cfg_two_stop), .irq_empty_en(irq_empty_en),
      .irq_end_en(irq_end_en), .txd(txd), .flag_empty(flag_empty), .flag_end(flag_end),
      .irq_empty(irq_empty), .irq_end(irq_end));

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic [7:0] d;
      logic       len7;
      logic [1:0] mode;
      logic       odd;
      logic       mp;
      logic       two;
   } frm_t;

   frm_t q[$];
   int   n_chk = 0, n_err = 0, frame_fails = 0;
   int   tick_always = 0;
   int   idle_run = 0, last_gap = -1;
   bit   in_fr = 0, fbad = 0, finished = 0;
   frm_t cur;
   int   k = 0, b = 0, bad_idx = 0;
   logic e_bit, bad_act;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   function automatic int data_len(frm_t f);
      return f.len7 ? 7 : 8;
   endfunction

   function automatic int ext_len(frm_t f);
      return (f.mode == 2'b01 || f.mode == 2'b10) ? 1 : 0;
   endfunction

   function automatic int frame_len(frm_t f);
      return 1 + data_len(f) + ext_len(f) + (f.two ? 2 : 1);
   endfunction

   function automatic logic frame_bit(frm_t f, int i);
      logic p;
      if (i == 0) return 1'b0;
      if (i <= data_len(f)) return f.d[i-1];
      if (ext_len(f) == 1 && i == data_len(f) + 1) begin
         p = f.len7 ? ^f.d[6:0] : ^f.d;
         return (f.mode == 2'b01) ? (p ^ f.odd) : f.mp;
      end
      return 1'b1;
   endfunction

   function automatic frm_t mk(logic [7:0] d);
      return '{d: d, len7: cfg_len7, mode: cfg_ext_mode, odd: cfg_par_odd,
               mp: cfg_mp_bit, two: cfg_two_stop};
   endfunction

   task automatic write_frame(input frm_t f);
      @(negedge clk);
      while (!flag_empty) @(negedge clk);
      @(posedge clk);
      #1 wr_en = 1'b1;
      wr_data = f.d;
      @(posedge clk);
      q.push_back(f);
      #1 wr_en = 1'b0;
   endtask

   task automatic wait_drained();
      @(negedge clk);
      while (q.size() != 0 || !flag_end) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // bit-rate strobe driver
   initial forever begin
      @(posedge clk);
      #1 bit_tick = (tick_always != 0) ? 1'b1 : ($urandom % 2 == 0);
   end

   // line decoder: one sample per strobe, TPB samples per bit
   initial forever begin
      @(negedge clk);
      if (rst_n && bit_tick) begin
         if (!in_fr) begin
            if (txd === 1'b0) begin
               if (q.size() == 0) begin
                  check(0, "R8", "start bit with nothing written", 0, 1);
               end else begin
                  in_fr = 1; cur = q[0]; k = 0; fbad = 0; last_gap = idle_run;
               end
            end else begin
               idle_run++;
            end
         end
         if (in_fr) begin
            b = k / TPB;
            e_bit = frame_bit(cur, b);
            if (txd !== e_bit && !fbad) begin
               fbad = 1; bad_idx = b; bad_act = txd;
            end
            if (k % TPB == 0 && b == frame_len(cur) - (cur.two ? 2 : 1))
               check(flag_end == (q.size() == 1), "R10",
                     "end flag at first stop bit", int'(flag_end), int'(q.size() == 1));
            k++;
            if (k == frame_len(cur) * TPB) begin
               if (fbad) frame_fails++;
               check(!fbad, "R4 R5 R6 R7",
                     $sformatf("frame d=%02h len7=%0d mode=%0d two=%0d bit %0d",
                               cur.d, cur.len7, cur.mode, cur.two, bad_idx),
                     int'(bad_act), int'(!bad_act));
               void'(q.pop_front());
               in_fr = 0; idle_run = 0;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL timeout: run did not complete");
      finish_run();
   end

   initial begin
      frm_t f1, f2;
      int   fails_before;
      void'($urandom(32'h5EED1234));

      // R1 reset state
      repeat (3) @(negedge clk);
      check(txd === 1'b1, "R1", "txd in reset", int'(txd), 1);
      check(flag_empty === 1'b1, "R1", "empty flag in reset", int'(flag_empty), 1);
      check(flag_end === 1'b1, "R1", "end flag in reset", int'(flag_end), 1);
      check(irq_empty === 1'b0 && irq_end === 1'b0, "R11", "requests masked",
            int'(irq_empty | irq_end), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      irq_empty_en = 1'b1; irq_end_en = 1'b1;
      @(negedge clk);
      check(irq_empty === 1'b1 && irq_end === 1'b1, "R11", "requests enabled",
            int'(irq_empty & irq_end), 1);
      check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);

      // R2 / R3 flag timing from idle, 8 bits, no extra slot, one stop
      tick_always = 0;
      @(posedge clk); #1 wr_en = 1'b1; wr_data = 8'hA5;
      @(posedge clk); q.push_back(mk(8'hA5)); #1 wr_en = 1'b0;
      @(negedge clk);
      check(flag_empty === 1'b0, "R2", "empty flag after write", int'(flag_empty), 0);
      check(flag_end === 1'b0, "R2", "end flag after write", int'(flag_end), 0);
      check(irq_empty === 1'b0 && irq_end === 1'b0, "R11", "requests follow flags",
            int'(irq_empty | irq_end), 0);
      @(negedge clk);
      check(flag_empty === 1'b1, "R3", "empty flag after load", int'(flag_empty), 1);
      check(txd === 1'b0, "R3", "start bit after load", int'(txd), 0);
      check(irq_empty === 1'b1, "R11", "empty request after load", int'(irq_empty), 1);
      wait_drained();
      check(flag_end === 1'b1 && irq_end === 1'b1, "R10", "end flag after frame",
            int'(flag_end & irq_end), 1);
      check(txd === 1'b1, "R8", "idle line after frame", int'(txd), 1);

      // R9 chaining: even parity, two stop bits, strobe every cycle
      tick_always = 1;
      cfg_ext_mode = 2'b01; cfg_par_odd = 1'b0; cfg_two_stop = 1'b1;
      write_frame(mk(8'h5A));
      write_frame(mk(8'hFF));
      wait_drained();
      check(last_gap == 0, "R9", "idle bits between chained frames", last_gap, 0);
      write_frame(mk(8'h01));
      wait_drained();
      check(last_gap > 0, "R8", "idle bits before unchained frame", last_gap, 1);

      // R12 configuration captured at load: 7 bits, marker bit 1, one stop
      cfg_len7 = 1'b1; cfg_ext_mode = 2'b10; cfg_mp_bit = 1'b1; cfg_two_stop = 1'b0;
      f1 = mk(8'hBC); f2 = mk(8'h43);
      fails_before = frame_fails;
      write_frame(f1);
      repeat (6) @(negedge clk);
      cfg_len7 = 1'b0; cfg_ext_mode = 2'b01; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
      write_frame(f2);
      cfg_mp_bit = 1'b0;
      wait_drained();
      check(frame_fails == fails_before, "R12", "frames kept captured settings",
            frame_fails - fails_before, 0);
      check(last_gap == 0, "R9", "chained frame with changed inputs", last_gap, 0);

      // random frames with random settings
      for (int i = 0; i < 48; i++) begin
         if ($urandom % 4 == 0) begin
            wait_drained();
            cfg_len7 = $urandom; cfg_ext_mode = $urandom; cfg_par_odd = $urandom;
            cfg_mp_bit = $urandom; cfg_two_stop = $urandom;
            irq_empty_en = $urandom; irq_end_en = $urandom;
            tick_always = $urandom % 2;
            @(negedge clk);
            check(irq_empty === (flag_empty & irq_empty_en) &&
                  irq_end === (flag_end & irq_end_en), "R11", "gated requests",
                  int'({irq_empty, irq_end}),
                  int'({flag_empty & irq_empty_en, flag_end & irq_end_en}));
         end
         write_frame(mk(8'($urandom)));
         if ($urandom % 3 == 0) repeat ($urandom % 40) @(negedge clk);
      end
      wait_drained();
      check(txd === 1'b1 && flag_end === 1'b1 && flag_empty === 1'b1, "R8",
            "final idle state", int'({txd, flag_end, flag_empty}), 7);
      finish_run();
   end

endmodule